// File: doc/BRIEF.md
# Triggered Sine and Cosine Reference Generator

This block produces a quadrature pair of reference waveforms, sine and cosine, at a fundamental frequency set by a 16-bit word. A normalised phase accumulator holds the angle as a fraction of one full turn. The accumulator moves forward only when the control loop raises its execution strobe. Between strobes the phase and all outputs are frozen, so the references keep in step with the controller's sampling instants and not with the fabric clock.

The frequency word is already scaled: it is the phase increment per execution step, in units of 2^-16 turn. When the sum reaches a full turn, the accumulator is cleared to zero and the excess is dropped. It does not wrap modulo one. The angle is turned into signed fixed-point sine and cosine by a quarter-wave table that is computed during elaboration. Each wave is also mapped to a 12-bit offset-binary code that can drive a converter directly.

Top module: `sincos_ref_gen`

## Requirements
- R1: While reset is asserted and after it is released, the phase is zero. sin_val reads 0, cos_val reads +16384 (+1.0 in Q2.14), sin_code reads 2048 and cos_code reads 4095.
- R2: A clock edge that samples exec_strobe high adds freq_word to the phase. Edges with exec_strobe low leave the phase unchanged.
- R3: If the sum is 65536 or more (one full turn), the phase becomes exactly 0 and the excess is discarded. For example, a phase of 40000 plus a step of 40000 gives 0, not 14464.
- R4: The outputs take the value of the new phase at the clock edge after the edge that advanced the phase. At all other times they hold their value.
- R5: sin_val equals round(sin(2*pi*k/1024) * 16384). Here k is the top 10 bits of the 16-bit phase, and sin_val is two's complement Q2.14.
- R6: cos_val equals round(cos(2*pi*k/1024) * 16384) for the same truncated phase k. At phase 0.25 turn it reads exactly 0, and at 0.5 turn it reads exactly -16384.
- R7: Each 12-bit code equals round((x + 1) * 2047.5), where x is the matching signed output divided by 16384. Halves round upward and the result is limited to 0..4095. So -1.0 gives 0, 0 gives 2048 and +1.0 gives 4095.
- R8: A freq_word of 0 keeps the waveform at its present angle even while strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| exec_strobe | input | 1 | Controller execution strobe, one step per sampled high cycle |
| freq_word | input | 16 | Phase increment per step, units of 2^-16 turn |
| sin_val | output | 16 | Sine, signed Q2.14 |
| cos_val | output | 16 | Cosine, signed Q2.14 |
| sin_code | output | 12 | Sine, offset binary 0..4095 |
| cos_code | output | 12 | Cosine, offset binary 0..4095 |

## Verification
A corrupted phase shows up at the ports one clock after the next strobe. It appears as a sine and cosine pair at the wrong angle, and the bench compares that pair against its own phase model after every step. A bad wrap rule shows up on the first step that crosses a full turn: the waves restart at some angle other than zero. Sweeps with a step that does not divide a turn evenly expose this within a few dozen strobes. A fault in the table or the quadrant folding appears as soon as the phase enters the affected quadrant. The code mapping is checked exactly against each sampled signed value.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

   // Quadrant of the normalised angle, top two index bits
   typedef enum logic [1:0] {
      QD_FIRST  = 2'd0,
      QD_SECOND = 2'd1,
      QD_THIRD  = 2'd2,
      QD_FOURTH = 2'd3
   } quadrant_t;

   // Channel order inside the evaluator
   localparam int CH_SIN = 0;
   localparam int CH_COS = 1;
   localparam int NUM_CH = 2;

endpackage

// File: rtl/sincos_phase_accum.sv
module sincos_phase_accum #(
   parameter int PH_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   input  logic [PH_W-1:0] step,
   output logic [PH_W-1:0] phase
);

   logic [PH_W:0]   sum;
   logic [PH_W-1:0] phase_d;

   always_comb begin
      sum = {1'b0, phase} + {1'b0, step};
      // a full turn or more collapses to zero, excess dropped
      phase_d = sum[PH_W] ? '0 : sum[PH_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (adv)
         phase <= phase_d;
   end

   // R2
   phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(phase));

   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      adv |=> (phase == '0) ||
              ({1'b0, phase} == {1'b0, $past(phase)} + {1'b0, $past(step)}));

endmodule

// File: rtl/sincos_eval.sv
module sincos_eval
   import sincos_pkg::*;
#(
   parameter int OUT_W = 16,
   parameter int LUT_A = 8
) (
   input  logic [LUT_A+1:0]        idx,
   output logic signed [OUT_W-1:0] sin_v,
   output logic signed [OUT_W-1:0] cos_v
);

   localparam int  QN   = 1 << LUT_A;
   localparam int  AMP  = 1 << (OUT_W - 2);
   localparam real HPI  = 1.5707963267948966;

   logic signed [OUT_W-1:0] qtab [0:QN];
   logic signed [OUT_W-1:0] wave [NUM_CH];

   // quarter-wave table, first quadrant including the peak
   for (genvar k = 0; k <= QN; k++) begin : g_tab
      localparam real ANG = HPI * k / QN;
      assign qtab[k] = OUT_W'($rtoi($sin(ANG) * AMP + 0.5));
   end

   // cosine is sine advanced by one quadrant
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      quadrant_t               qd;
      logic [LUT_A-1:0]        off;
      logic [LUT_A:0]          mirror;
      logic [LUT_A:0]          addr;
      logic signed [OUT_W-1:0] mag;

      always_comb begin
         qd     = quadrant_t'(idx[LUT_A+1:LUT_A] + 2'(ch));
         off    = idx[LUT_A-1:0];
         mirror = (LUT_A+1)'(QN) - {1'b0, off};
         addr   = (qd == QD_SECOND || qd == QD_FOURTH) ? mirror : {1'b0, off};
         mag    = qtab[addr];
         wave[ch] = (qd == QD_THIRD || qd == QD_FOURTH) ? -mag : mag;
      end
   end

   assign sin_v = wave[CH_SIN];
   assign cos_v = wave[CH_COS];

endmodule

// File: rtl/sincos_dac_map.sv
module sincos_dac_map #(
   parameter int OUT_W = 16,
   parameter int DAC_W = 12
) (
   input  logic signed [OUT_W-1:0] val,
   output logic [DAC_W-1:0]        code
);

   localparam int AMP     = 1 << (OUT_W - 2);
   localparam int DAC_MAX = (1 << DAC_W) - 1;
   localparam int PW      = OUT_W + DAC_W + 2;

   logic signed [OUT_W:0] biased;
   logic [PW-1:0]         prod;
   logic [PW-1:0]         rnd;

   always_comb begin
      // shift range -AMP..AMP onto 0..2*AMP
      biased = {val[OUT_W-1], val} + (OUT_W+1)'(AMP);
      if (biased[OUT_W])
         prod = '0;
      else
         prod = PW'(biased) * PW'(DAC_MAX);
      // divide by 2*AMP, halves rounded up
      rnd = (prod + PW'(AMP)) >> (OUT_W - 1);
      code = (rnd > PW'(DAC_MAX)) ? DAC_W'(DAC_MAX) : rnd[DAC_W-1:0];
   end

endmodule

// File: rtl/sincos_ref_gen.sv
module sincos_ref_gen #(
   parameter int PH_W  = 16,
   parameter int LUT_A = 8,
   parameter int OUT_W = 16,
   parameter int DAC_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    exec_strobe,
   input  logic [PH_W-1:0]         freq_word,
   output logic signed [OUT_W-1:0] sin_val,
   output logic signed [OUT_W-1:0] cos_val,
   output logic [DAC_W-1:0]        sin_code,
   output logic [DAC_W-1:0]        cos_code
);

   localparam int IDX_W    = LUT_A + 2;
   localparam int AMP      = 1 << (OUT_W - 2);
   localparam int DAC_MAX  = (1 << DAC_W) - 1;
   localparam int DAC_MID  = 1 << (DAC_W - 1);
   localparam int SQ_W     = 2 * OUT_W + 2;

   if (PH_W < IDX_W) begin : g_bad_ph
      $error("phase width must cover the table index");
   end
   if (LUT_A < 2 || LUT_A > 12) begin : g_bad_lut
      $error("table address width out of range");
   end
   if (OUT_W < 4 || OUT_W > 30) begin : g_bad_out
      $error("output width out of range");
   end
   if (DAC_W < 2 || DAC_W > OUT_W) begin : g_bad_dac
      $error("converter width out of range");
   end

   logic [PH_W-1:0]         phase;
   logic                    upd_q;
   logic signed [OUT_W-1:0] sin_c, cos_c;
   logic [DAC_W-1:0]        sin_code_c, cos_code_c;

   sincos_phase_accum #(.PH_W(PH_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .adv   (exec_strobe),
      .step  (freq_word),
      .phase (phase)
   );

   sincos_eval #(.OUT_W(OUT_W), .LUT_A(LUT_A)) u_eval (
      .idx   (phase[PH_W-1 -: IDX_W]),
      .sin_v (sin_c),
      .cos_v (cos_c)
   );

   sincos_dac_map #(.OUT_W(OUT_W), .DAC_W(DAC_W)) u_map_sin (
      .val  (sin_c),
      .code (sin_code_c)
   );

   sincos_dac_map #(.OUT_W(OUT_W), .DAC_W(DAC_W)) u_map_cos (
      .val  (cos_c),
      .code (cos_code_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         upd_q    <= 1'b0;
         sin_val  <= '0;
         cos_val  <= OUT_W'(AMP);
         sin_code <= DAC_W'(DAC_MID);
         cos_code <= DAC_W'(DAC_MAX);
      end else begin
         upd_q <= exec_strobe;
         if (upd_q) begin
            sin_val  <= sin_c;
            cos_val  <= cos_c;
            sin_code <= sin_code_c;
            cos_code <= cos_code_c;
         end
      end
   end

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !upd_q |=> ($stable(sin_val) && $stable(cos_val) &&
                  $stable(sin_code) && $stable(cos_code)));

   // R6
   logic signed [SQ_W-1:0] mag_err;
   assign mag_err = SQ_W'(sin_val) * SQ_W'(sin_val) + SQ_W'(cos_val) * SQ_W'(cos_val)
                    - SQ_W'(AMP) * SQ_W'(AMP);
   quadrature_chk: assert property (@(posedge clk) disable iff (rst)
      (mag_err <= SQ_W'(4 * AMP)) && (mag_err >= -SQ_W'(4 * AMP)));

   // R7
   code_top_chk: assert property (@(posedge clk) disable iff (rst)
      (sin_val == OUT_W'(AMP)) |-> (sin_code == DAC_W'(DAC_MAX)));

   // R7
   code_mid_chk: assert property (@(posedge clk) disable iff (rst)
      (cos_val == '0) |-> (cos_code == DAC_W'(DAC_MID)));

endmodule

// File: tb/sincos_ref_gen_test.sv
module sincos_ref_gen_test;

   localparam int  AMP = 16384;
   localparam real TWO_PI = 6.283185307179586;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        exec_strobe = 1'b0;
   logic [15:0] freq_word = '0;
   logic signed [15:0] sin_val, cos_val;
   logic [11:0] sin_code, cos_code;

   int checks = 0;
   int fails  = 0;
   int ph_m   = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sincos_ref_gen uut (
      .clk         (clk),
      .rst         (rst),
      .exec_strobe (exec_strobe),
      .freq_word   (freq_word),
      .sin_val     (sin_val),
      .cos_val     (cos_val),
      .sin_code    (sin_code),
      .cos_code    (cos_code)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_near(input string req, input string what, input int act, input int exp);
      checks++;
      if (act > exp + 1 || act < exp - 1) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int round_r(input real x);
      return $rtoi($floor(x + 0.5));
   endfunction

   function automatic int code_of(input int s);
      return round_r((real'(s) / AMP + 1.0) * 2047.5);
   endfunction

   // one strobe, then confirm the outputs wait one more edge
   task automatic step_once();
      int s0, c0;
      s0 = sin_val; c0 = cos_val;
      exec_strobe = 1'b1;
      @(negedge clk);
      exec_strobe = 1'b0;
      ph_m = ph_m + freq_word;
      if (ph_m >= 65536) ph_m = 0;
      check_eq("R4", "sin before update edge", sin_val, s0);
      check_eq("R4", "cos before update edge", cos_val, c0);
      @(negedge clk);
   endtask

   task automatic check_model(input string tag);
      int k;
      real a;
      k = ph_m >> 6;
      a = TWO_PI * k / 1024.0;
      check_near("R5", {tag, " sine"}, sin_val, round_r($sin(a) * AMP));
      check_near("R6", {tag, " cosine"}, cos_val, round_r($cos(a) * AMP));
      check_eq("R7", {tag, " sine code"}, sin_code, code_of(sin_val));
      check_eq("R7", {tag, " cosine code"}, cos_code, code_of(cos_val));
   endtask

   task automatic t_reset();
      check_eq("R1", "reset sine", sin_val, 0);
      check_eq("R1", "reset cosine", cos_val, AMP);
      check_eq("R1", "reset sine code", sin_code, 2048);
      check_eq("R1", "reset cosine code", cos_code, 4095);
   endtask

   task automatic t_hold();
      freq_word = 16'd9000;
      repeat (10) @(negedge clk);
      check_eq("R2", "no strobe sine", sin_val, 0);
      check_eq("R4", "no strobe cosine", cos_val, AMP);
   endtask

   task automatic t_quarter();
      freq_word = 16'd16384;
      step_once();
      check_eq("R5", "quarter sine", sin_val, AMP);
      check_eq("R6", "quarter cosine", cos_val, 0);
      check_eq("R7", "quarter codes", {20'd0, sin_code}, 4095);
      check_eq("R7", "quarter cos code", cos_code, 2048);
      step_once();
      check_eq("R5", "half sine", sin_val, 0);
      check_eq("R6", "half cosine", cos_val, -AMP);
      check_eq("R7", "half cos code", cos_code, 0);
      step_once();
      check_eq("R5", "three quarter sine", sin_val, -AMP);
      check_eq("R7", "three quarter sin code", sin_code, 0);
      step_once();
      check_eq("R3", "full turn sine", sin_val, 0);
      check_eq("R3", "full turn cosine", cos_val, AMP);
   endtask

   task automatic t_discard();
      freq_word = 16'd40000;
      step_once();
      check_model("R2 first step");
      step_once();
      check_eq("R3", "excess dropped sine", sin_val, 0);
      check_eq("R3", "excess dropped cosine", cos_val, AMP);
      step_once();
      check_model("R3 after restart");
   endtask

   task automatic t_freeze();
      int s0, c0;
      freq_word = 16'd3000;
      step_once();
      s0 = sin_val; c0 = cos_val;
      freq_word = 16'd0;
      for (int i = 0; i < 5; i++) step_once();
      check_eq("R8", "zero step sine", sin_val, s0);
      check_eq("R8", "zero step cosine", cos_val, c0);
   endtask

   task automatic t_sweep(input logic [15:0] f, input int n);
      freq_word = f;
      for (int i = 0; i < n; i++) begin
         step_once();
         check_model("R5 sweep");
         repeat (i % 3) @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_hold();
      t_quarter();
      t_discard();
      t_freeze();
      t_sweep(16'd1234, 150);
      t_sweep(16'd20011, 60);
      t_sweep(16'd65535, 4);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule